// File: doc/BRIEF.md
# Sequential Restoring Binary Divider

This block divides one unsigned fixed-point operand by another using the restoring method. It produces one quotient bit per clock. A single-cycle start pulse captures an N-bit dividend and an N-bit divisor. The dividend goes into a shifting quotient register, and a partial-remainder register one bit wider than the operands starts at zero. On each clock the remainder and quotient shift left together as one pair. The divisor is then subtracted on trial. If the trial difference is negative, the value from before the subtraction is kept, so the restore takes no extra cycle.

While an operation is in progress, the busy output is high. When the quotient and remainder are ready, a one-cycle done pulse marks completion. The result outputs keep the last completed answer until a later operation finishes. A zero divisor never enters the iteration. It finishes at once with a flag raised and a defined result.

Top module: `restoring_div`

## Requirements
- R1: While reset is held (synchronous, active low), and after it is released, busy, done, the divide-by-zero flag, the quotient output and the remainder output are all zero.
- R2: A start accepted with a non-zero divisor at clock edge k drives busy high from edge k until edge k+WIDTH. Done is then high for exactly one cycle, following edge k+WIDTH.
- R3: At completion, the quotient output equals floor(dividend / divisor) and the remainder output equals dividend mod divisor. Both are unsigned, computed from the operands captured at the accepted start.
- R4: A start pulse that arrives while busy is high is ignored. The running operation keeps its operands, its result and its completion cycle.
- R5: A start accepted with a zero divisor leaves busy low and raises done for one cycle after that edge. The flag goes to 1, the quotient output to all ones, and the remainder output to the dividend.
- R6: The quotient, remainder and divide-by-zero outputs change only at a completion edge. They hold their values in every cycle in which done is low. A completed non-zero division clears the flag.
- R7: A start presented in the cycle in which done is high is accepted. The new operation then follows R2 or R5.
- R8: Done and busy are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled when busy is low |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Last completed quotient |
| remainder_o | output | WIDTH | Last completed remainder |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |

## Verification
A completion and a new acceptance can happen in the same cycle. A start is presented while done is high, so the result registers are being read out just as the iteration registers are reloaded. The bench provokes this by chaining operations back to back: it places a start on the cycle in which its model predicts done. This is tried with both a non-zero and a zero divisor. A behavioural model, using integer division and modulo, predicts busy, done, the flag and both results on every clock. Any early reload, lost start or overwritten result then shows up as a mismatch in that cycle or the next.

// File: rtl/rdiv_pkg.sv
// Package: shared helpers for the restoring divider.
// Assumes: nothing; holds only a width helper used by the submodules.
package rdiv_pkg;

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rdiv_step.sv
// Module: one restoring iteration, purely combinational.
// What it does: shifts {remainder, quotient} left by one, subtracts the
// divisor from the widened remainder on trial, and keeps either the
// difference or the pre-subtraction value depending on the sign.
// Assumes: WIDTH >= 2 and the incoming remainder is below the divisor,
// so the trial difference always fits in WIDTH+1 bits as a signed value.
module rdiv_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH:0]   rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;
    logic           negative;

    // Shift, subtract on trial, then keep or restore by selection.
    always_comb begin
        shifted  = {rem_i[WIDTH-1:0], quo_i[WIDTH-1]};
        trial    = shifted - {1'b0, dvs_i};
        negative = trial[WIDTH];
        rem_o    = negative ? shifted : trial;
        quo_o    = {quo_i[WIDTH-2:0], ~negative};
    end
endmodule

// File: rtl/rdiv_ctrl.sv
// Module: sequencing for the divider.
// What it does: accepts a start only when idle, counts WIDTH iterations,
// flags the final one, and emits a one-cycle done pulse after the last
// iteration or directly after a zero-divisor start.
// Assumes: div_zero_i reflects the divisor presented alongside start_i.
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             div_zero_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic             last_o,
    output logic             zero_take_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    // Decode acceptance and the final iteration from the current state.
    always_comb begin
        accept      = start_i && !busy_q;
        load_o      = accept && !div_zero_i;
        zero_take_o = accept && div_zero_i;
        last_o      = busy_q && (cnt_q == CNT_W'(1));
    end

    // Hold busy, the iteration count and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_o || zero_take_o;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(WIDTH);
            end else if (busy_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (last_o) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/rdiv_datapath.sv
// Module: working registers and result registers of the divider.
// What it does: loads the operands on an accepted start, advances one
// restoring step per busy cycle, and copies the answer into the result
// registers on the final step or on a zero-divisor start.
// Assumes: load_i, last_i and zero_take_i are mutually exclusive.
module rdiv_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             busy_i,
    input  logic             last_i,
    input  logic             zero_take_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o
);
    logic [WIDTH:0]   rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH:0]   rem_nxt;
    logic [WIDTH-1:0] quo_nxt;
    logic [WIDTH-1:0] res_quo_q;
    logic [WIDTH-1:0] res_rem_q;
    logic             res_dz_q;

    rdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (rem_q),
        .quo_i (quo_q),
        .dvs_i (dvs_q),
        .rem_o (rem_nxt),
        .quo_o (quo_nxt)
    );

    // Load operands on acceptance, then iterate while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dvs_q <= divisor_i;
        end else if (busy_i) begin
            rem_q <= rem_nxt;
            quo_q <= quo_nxt;
        end
    end

    // Capture the answer at completion and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_quo_q <= '0;
            res_rem_q <= '0;
            res_dz_q  <= 1'b0;
        end else if (last_i) begin
            res_quo_q <= quo_nxt;
            res_rem_q <= rem_nxt[WIDTH-1:0];
            res_dz_q  <= 1'b0;
        end else if (zero_take_i) begin
            res_quo_q <= '1;
            res_rem_q <= dividend_i;
            res_dz_q  <= 1'b1;
        end
    end

    assign quotient_o  = res_quo_q;
    assign remainder_o = res_rem_q;
    assign div_zero_o  = res_dz_q;
endmodule

// File: rtl/restoring_div.sv
// Module: top of the sequential restoring divider.
// What it does: ties the sequencer to the datapath; WIDTH iterations per
// non-zero division, immediate completion on a zero divisor.
// Assumes: WIDTH >= 2; operands are unsigned and need only be valid in
// the cycle of the accepted start.
module restoring_div
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o
);
    logic             load;
    logic             last;
    logic             zero_take;
    logic             div_zero_in;
    logic [CNT_W-1:0] iter_cnt;

    // Detect a zero divisor at the input.
    always_comb div_zero_in = (divisor_i == '0);

    rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .div_zero_i  (div_zero_in),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .load_o      (load),
        .last_o      (last),
        .zero_take_o (zero_take),
        .cnt_o       (iter_cnt)
    );

    rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .busy_i      (busy_o),
        .last_i      (last),
        .zero_take_i (zero_take),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .div_zero_o  (div_zero_o)
    );
endmodule

// File: rtl/rdiv_checker.sv
// Module: protocol properties for restoring_div, attached by bind.
// Assumes: reset is held for at least one clock at the start of time.
module rdiv_checker
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = cnt_width(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] divisor_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] quotient_o,
    input logic [WIDTH-1:0] remainder_o,
    input logic             div_zero_o,
    input logic [CNT_W-1:0] iter_cnt
);
    // R8: completion and activity are exclusive.
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R8: done lasts one cycle unless a zero-divisor start follows at once.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(start_i && divisor_i == '0)) |=> !done_o);

    // R2: busy only rises after a start.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R4: a start during an operation does not disturb the count.
    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && iter_cnt > CNT_W'(1)) |=> (busy_o && iter_cnt == $past(iter_cnt) - CNT_W'(1)));

    // R5: the zero-divisor flag comes with an all-ones quotient.
    assert_zero_quotient_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (quotient_o == '1));

    // R6: results only move at a completion edge.
    assert_hold_results_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

bind restoring_div rdiv_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .div_zero_o  (div_zero_o),
    .iter_cnt    (iter_cnt)
);

// File: tb/restoring_div_tb.sv
module restoring_div_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic         busy, done, dz;
    logic [W-1:0] quo, rem;

    int checks = 0;
    int fails  = 0;
    string req = "R1";

    // behavioural reference state
    int m_busy = 0, m_done = 0, m_dz = 0, m_cnt = 0;
    int m_q = 0, m_r = 0, p_q = 0, p_r = 0;

    always #2 clk = ~clk;

    restoring_div #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dividend_i(dvd), .divisor_i(dvs),
        .busy_o(busy), .done_o(done),
        .quotient_o(quo), .remainder_o(rem), .div_zero_o(dz)
    );

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_cnt = 0; m_q = 0; m_r = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r; m_dz = 0;
                end
            end else if (start) begin
                if (dvs == 0) begin
                    m_done = 1; m_q = (1 << W) - 1; m_r = int'(dvd); m_dz = 1;
                end else begin
                    m_busy = 1; m_cnt = W;
                    p_q = int'(dvd) / int'(dvs);
                    p_r = int'(dvd) % int'(dvs);
                end
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and compare every output.
    task automatic tick();
        @(negedge clk);
        chk("busy", int'(busy), m_busy);
        chk("done", int'(done), m_done);
        chk("div_zero", int'(dz), m_dz);
        chk("quotient", int'(quo), m_q);
        chk("remainder", int'(rem), m_r);
    endtask

    task automatic run_until_done();
        for (int i = 0; i < 4 * W; i++) begin
            tick();
            if (m_done != 0) break;
        end
    endtask

    task automatic launch(input int a, input int b);
        dvd = W'(a); dvs = W'(b); start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic divide(input string r, input int a, input int b);
        req = r;
        launch(a, b);
        run_until_done();
        tick();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state during and after reset
        req = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        // R2 / R3: ordinary divisions
        divide("R2", 100, 7);
        divide("R3", 255, 1);
        divide("R3", 0, 5);
        divide("R3", 5, 9);
        divide("R3", 255, 255);
        divide("R3", 200, 16);
        divide("R3", 254, 127);
        // R5: zero divisor
        divide("R5", 77, 0);
        // R6: a non-zero division clears the flag; outputs hold while idle
        divide("R6", 9, 3);
        req = "R6";
        dvd = 8'd13; dvs = 8'd0;
        for (int i = 0; i < 5; i++) tick();
        // R4: start pulses while busy are ignored
        req = "R4";
        launch(180, 11);
        dvd = 8'd3; dvs = 8'd0; start = 1'b1;
        tick(); tick();
        dvd = 8'd99; dvs = 8'd2;
        tick();
        start = 1'b0;
        run_until_done();
        tick();
        // R7: start in the done cycle, non-zero then zero divisor
        req = "R7";
        launch(143, 12);
        run_until_done();
        launch(66, 0);
        launch(250, 3);
        run_until_done();
        launch(41, 6);
        run_until_done();
        tick();
        // R8 and R3: assorted operands, compared every cycle
        req = "R8";
        for (int i = 0; i < 60; i++) begin
            divide((i % 2 == 0) ? "R3" : "R8", int'($urandom_range(0, 255)),
                   (i % 9 == 0) ? 0 : int'($urandom_range(1, 255)));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule